// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two 12-bit elements of GF(4096). The field is built as a quadratic extension over GF(64), and GF(64) is reduced by the polynomial x^6+x+1. Each operand is split into a high 6-bit half and a low 6-bit half. Three GF(64) products and one multiply by a fixed GF(64) constant then form the two result halves.

A second mode is meant for building log and antilog tables for a Reed-Solomon codec. It multiplies its single operand by the fixed element 0xE01, except that an operand of zero gives one. If each result is fed back as the next operand, the block walks through successive powers. Every accepted operation yields a registered result one clock later, flagged by a valid output.

Top module: `gf4096_mul_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_vld` is 0 and `res` is 0.
- R2: An operation accepted on a rising edge with `in_vld` high sets `res_vld` high for exactly the next cycle, with `res` valid in that cycle. A cycle with `in_vld` low gives `res_vld` low in the next cycle.
- R3: With `step_mode` = 0, `res` is the tower product of `opa` and `opb`. Write ah/al for `opa`[11:6]/[5:0] and bh/bl for `opb`[11:6]/[5:0]. Products are in GF(64) modulo x^6+x+1. Then `res`[11:6] = (ah^al)·(bh^bl) ^ al·bl and `res`[5:0] = (ah·bh)·0x21 ^ al·bl.
- R4: With `step_mode` = 0, a zero in either operand gives `res` = 0.
- R5: With `step_mode` = 0, an operand equal to 0x001 gives the other operand unchanged.
- R6: With `step_mode` = 0, swapping `opa` and `opb` gives the same `res`.
- R7: With `step_mode` = 1 and `opa` = 0, `res` = 0x001.
- R8: With `step_mode` = 1 and `opa` nonzero, `res` is the R3 product of `opa` and 0xE01, whatever the value of `opb`.
- R9: When `in_vld` is low, `res` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operands and mode are valid this cycle |
| step_mode | input | 1 | 0 = multiply opa by opb, 1 = power step on opa |
| opa | input | 12 | First operand, or the step input |
| opb | input | 12 | Second operand, ignored in step mode |
| res_vld | output | 1 | Result valid, one cycle after in_vld |
| res | output | 12 | Registered result |

## Verification
A fault in any half-field multiplier or in the combining XORs shows up as a wrong `res` in the cycle right after the operation is accepted. Nothing is stored between operations except the output register, so a fault never hides and never builds up. A fault in the reduction constant or the 0x21 scaling corrupts only operands whose halves reach the reduction path. For that reason, many spread operand patterns are compared against a reference model that carries out the reduction by polynomial division. A long chain of power steps is compared step by step, so a fault in the step constant or the zero rule is caught at the first element it touches.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;
  localparam int HALF_W = 6;
  localparam int FULL_W = 2 * HALF_W;
  // low bits of the GF(64) reduction polynomial x^6 + x + 1
  localparam logic [HALF_W-1:0] RED_LOW = 6'h03;
  // GF(64) constant that scales the high-by-high product into the low half
  localparam logic [HALF_W-1:0] BETA = 6'h21;
  // fixed multiplier used by the power step
  localparam logic [FULL_W-1:0] STEP_K = 12'hE01;
  localparam logic [FULL_W-1:0] ONE = 12'h001;

  typedef enum logic {
    MODE_MUL  = 1'b0,
    MODE_STEP = 1'b1
  } op_mode_e;

  // doubling in GF(64): shift left, fold the carry back with the polynomial
  function automatic logic [HALF_W-1:0] gf64_xtime(input logic [HALF_W-1:0] v);
    gf64_xtime = {v[HALF_W-2:0], 1'b0} ^ (v[HALF_W-1] ? RED_LOW : '0);
  endfunction
endpackage

// File: rtl/gf64_mul_unit.sv
module gf64_mul_unit
  import gf_tower_pkg::*;
(
  input  logic [HALF_W-1:0] x,
  input  logic [HALF_W-1:0] y,
  output logic [HALF_W-1:0] p
);
  // accumulated sum and running multiple of y, one slot per bit of x
  logic [HALF_W-1:0] acc [HALF_W+1];
  logic [HALF_W-1:0] ymul [HALF_W+1];

  assign acc[0]  = '0;
  assign ymul[0] = y;

  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    assign acc[i+1]  = acc[i] ^ ({HALF_W{x[i]}} & ymul[i]);
    assign ymul[i+1] = gf64_xtime(ymul[i]);
  end

  assign p = acc[HALF_W];
endmodule

// File: rtl/gf_tower_core.sv
module gf_tower_core
  import gf_tower_pkg::*;
(
  input  logic [FULL_W-1:0] a,
  input  logic [FULL_W-1:0] b,
  output logic [FULL_W-1:0] prod
);
  logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [HALF_W-1:0] a_sum, b_sum;
  logic [HALF_W-1:0] p_sum, p_lo, p_hi, p_hi_scaled;
  logic [HALF_W-1:0] half_hi, half_lo;

  assign a_hi  = a[FULL_W-1:HALF_W];
  assign a_lo  = a[HALF_W-1:0];
  assign b_hi  = b[FULL_W-1:HALF_W];
  assign b_lo  = b[HALF_W-1:0];
  assign a_sum = a_hi ^ a_lo;
  assign b_sum = b_hi ^ b_lo;

  gf64_mul_unit u_sum   (.x(a_sum), .y(b_sum), .p(p_sum));
  gf64_mul_unit u_lo    (.x(a_lo),  .y(b_lo),  .p(p_lo));
  gf64_mul_unit u_hi    (.x(a_hi),  .y(b_hi),  .p(p_hi));
  gf64_mul_unit u_scale (.x(p_hi),  .y(BETA),  .p(p_hi_scaled));

  assign half_hi = p_sum ^ p_lo;
  assign half_lo = p_hi_scaled ^ p_lo;
  assign prod    = {half_hi, half_lo};
endmodule

// File: rtl/gf_step_mux.sv
module gf_step_mux
  import gf_tower_pkg::*;
(
  input  op_mode_e          mode,
  input  logic [FULL_W-1:0] in_a,
  input  logic [FULL_W-1:0] in_b,
  output logic [FULL_W-1:0] mul_a,
  output logic [FULL_W-1:0] mul_b,
  output logic              force_one
);
  always_comb begin
    mul_a     = in_a;
    mul_b     = in_b;
    force_one = 1'b0;
    if (mode == MODE_STEP) begin
      mul_b     = STEP_K;
      force_one = (in_a == '0);
    end
  end
endmodule

// File: rtl/gf4096_mul_top.sv
module gf4096_mul_top
  import gf_tower_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              step_mode,
  input  logic [FULL_W-1:0] opa,
  input  logic [FULL_W-1:0] opb,
  output logic              res_vld,
  output logic [FULL_W-1:0] res
);
  op_mode_e          mode;
  logic [FULL_W-1:0] mul_a, mul_b, core_prod, next_res;
  logic              force_one;

  assign mode = op_mode_e'(step_mode);

  gf_step_mux u_mux (
    .mode(mode), .in_a(opa), .in_b(opb),
    .mul_a(mul_a), .mul_b(mul_b), .force_one(force_one)
  );

  gf_tower_core u_core (.a(mul_a), .b(mul_b), .prod(core_prod));

  assign next_res = force_one ? ONE : core_prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res     <= '0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) res <= next_res;
    end
  end

  // R2: valid output tracks valid input one cycle later
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> res_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !res_vld);
  // R4: zero operand in multiply mode gives zero
  a_r4_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !step_mode && (opa == '0 || opb == '0)) |=> (res == '0));
  // R5: multiplying by one returns the other operand
  a_r5_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !step_mode && opa == ONE) |=> (res == $past(opb)));
  // R7: a zero step input maps to one
  a_r7_step_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && step_mode && opa == '0) |=> (res == ONE));
  // R8: a nonzero step input never yields zero
  a_r8_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && step_mode && opa != '0) |=> (res != '0));
  // R9: result holds while idle
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(res));
endmodule

// File: tb/tb_gf4096_mul_top.sv
module tb_gf4096_mul_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic        step_mode = 1'b0;
  logic [11:0] opa = '0;
  logic [11:0] opb = '0;
  logic        res_vld;
  logic [11:0] res;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  gf4096_mul_top dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .step_mode(step_mode),
    .opa(opa), .opb(opb), .res_vld(res_vld), .res(res)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference: carry-less product, then polynomial division by x^6+x+1
  function automatic logic [5:0] ref64(input logic [5:0] x, input logic [5:0] y);
    logic [10:0] t;
    t = '0;
    for (int i = 0; i < 6; i++) if (x[i]) t = t ^ (11'(y) << i);
    for (int k = 10; k >= 6; k--) if (t[k]) t = t ^ (11'h043 << (k - 6));
    return t[5:0];
  endfunction

  function automatic logic [11:0] ref_mul(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] h, l;
    l = ref64(a[5:0], b[5:0]);
    h = ref64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ l;
    l = ref64(ref64(a[11:6], b[11:6]), 6'h21) ^ l;
    return {h, l};
  endfunction

  function automatic logic [11:0] ref_step(input logic [11:0] a);
    return (a == 0) ? 12'h001 : ref_mul(a, 12'hE01);
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  // drive one operation at a falling edge, sample at the next falling edge
  task automatic run_op(input logic m, input logic [11:0] a, input logic [11:0] b,
                        output logic [11:0] r, output logic v);
    @(negedge clk);
    in_vld = 1'b1; step_mode = m; opa = a; opb = b;
    @(negedge clk);
    r = res; v = res_vld;
    in_vld = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", {11'd0, res_vld}, 12'd0);
    check("R1", res, 12'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {11'd0, res_vld}, 12'd0);
  endtask

  task automatic t_latency();
    logic [11:0] r; logic v;
    run_op(1'b0, 12'h123, 12'h456, r, v);
    check("R2", {11'd0, v}, 12'd1);
    @(negedge clk);
    check("R2", {11'd0, res_vld}, 12'd0);
  endtask

  task automatic t_products();
    logic [11:0] r, a, b; logic v;
    a = 12'h5A3; b = 12'h0F1;
    for (int i = 0; i < 200; i++) begin
      run_op(1'b0, a, b, r, v);
      check("R3", r, ref_mul(a, b));
      a = {a[10:0], a[11] ^ a[10] ^ a[9] ^ a[3]};
      b = b * 12'd37 + 12'd11;
    end
    run_op(1'b0, 12'hFFF, 12'hFFF, r, v); check("R3", r, ref_mul(12'hFFF, 12'hFFF));
    run_op(1'b0, 12'h040, 12'h040, r, v); check("R3", r, ref_mul(12'h040, 12'h040));
    run_op(1'b0, 12'h020, 12'h020, r, v); check("R3", r, ref_mul(12'h020, 12'h020));
  endtask

  task automatic t_zero_one();
    logic [11:0] r; logic v;
    run_op(1'b0, 12'h000, 12'hABC, r, v); check("R4", r, 12'h000);
    run_op(1'b0, 12'h7E5, 12'h000, r, v); check("R4", r, 12'h000);
    run_op(1'b0, 12'h001, 12'hABC, r, v); check("R5", r, 12'hABC);
    run_op(1'b0, 12'hFC3, 12'h001, r, v); check("R5", r, 12'hFC3);
  endtask

  task automatic t_commute();
    logic [11:0] r1, r2, a; logic v;
    a = 12'h9D2;
    for (int i = 0; i < 20; i++) begin
      run_op(1'b0, a, ~a + 12'd3, r1, v);
      run_op(1'b0, ~a + 12'd3, a, r2, v);
      check("R6", r2, r1);
      a = a * 12'd29 + 12'd7;
    end
  endtask

  task automatic t_step();
    logic [11:0] r, x; logic v;
    run_op(1'b1, 12'h000, 12'h555, r, v); check("R7", r, 12'h001);
    run_op(1'b1, 12'h001, 12'h000, r, v); check("R8", r, 12'hE01);
    run_op(1'b1, 12'h3C7, 12'h000, r, v); check("R8", r, ref_step(12'h3C7));
    run_op(1'b1, 12'h3C7, 12'hFFF, r, v); check("R8", r, ref_step(12'h3C7));
    x = 12'h001;
    for (int i = 0; i < 64; i++) begin
      run_op(1'b1, x, 12'h2A5, r, v);
      check("R8", r, ref_step(x));
      x = r;
    end
  endtask

  task automatic t_hold();
    logic [11:0] r; logic v;
    run_op(1'b0, 12'h321, 12'h0AB, r, v);
    @(negedge clk);
    opa = 12'hFFF; opb = 12'hFFF; step_mode = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9", res, ref_mul(12'h321, 12'h0AB));
    check("R9", {11'd0, res_vld}, 12'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_latency();
    t_products();
    t_zero_one();
    t_commute();
    t_step();
    t_hold();
    done = 1;
    finish_run();
  end
endmodule